// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of an 8051-style external memory bus from the oscillator clock: an address-latch strobe (`ale`, active high) and a program-fetch read strobe (`psen_n`, active low). A machine cycle lasts `CYC_LEN` oscillator periods (six by default), counted by a phase counter that runs 0 to `CYC_LEN-1` and restarts at 0 on reset. At the last phase of each machine cycle, the block samples the CPU's view of the coming cycle: the program counter, an external data-move flag, a software quiet bit, and the idle and power-down requests. It then holds one operating mode for the whole next machine cycle.

There are four modes. MODE_TOGGLE drives both strobes normally. MODE_QUIET holds the address-latch strobe low and raises `ale_pd_req`, which asks the pad to pull the pin down so an external address latch stays still. MODE_IDLE parks both strobes high. MODE_PDOWN parks `ale` low and `psen_n` high. At every machine-cycle boundary, a single priority decision picks the next mode, whatever the current one is. The transition to MODE_PDOWN (power-down requested) wins over the transition to MODE_IDLE (idle requested). Next comes the transition to MODE_QUIET: the quiet bit is set and nothing forces toggling. Otherwise the transition returns to MODE_TOGGLE. Three conditions force toggling: an external data move, a fetch address at or above `IMEM_LIMIT`, or a low external-access level latched during reset. Reset enters MODE_TOGGLE.

Top module: `xbus_strobe_gen`

## Requirements
- R1: In MODE_TOGGLE, `ale` is high in phases 0 to `CYC_LEN/2-1` and low in the other phases of every machine cycle, and it only rises at phase 0.
- R2: In MODE_TOGGLE, a cycle fetches externally when the latched external-access level is low or the sampled `pc` is at or above `IMEM_LIMIT`. In such a cycle without a data move, `psen_n` is low in exactly phases `CYC_LEN/2-1` and `CYC_LEN-1`. In all other cycles it stays high.
- R3: In a cycle sampled with `xdata_mv` high, both `psen_n` activations are skipped (it stays high all cycle), while `ale` still toggles as in R1.
- R4: With `quiet_en` high, internal fetch, no data move and no low-power request, the cycle is in MODE_QUIET: `ale` is low in all phases and `ale_pd_req` is high.
- R5: The quiet bit is overridden in any of three cases: `xdata_mv` is high, `pc` is at or above `IMEM_LIMIT`, or the latched external-access level is low. `ale` then toggles as in R1 and `ale_pd_req` is low.
- R6: In a cycle sampled with `idle_mode` high (and `pdown_mode` low), `ale` and `psen_n` are both high in all phases and `ale_pd_req` is low.
- R7: In a cycle sampled with `pdown_mode` high, `psen_n` is high and `ale` is low in all phases, and `ale_pd_req` equals the sampled `quiet_en`. Power-down takes priority over idle.
- R8: `ea_pin` is latched on clock edges while `rst_n` is low. Changes of `ea_pin` after reset have no effect on the strobes.
- R9: Inputs are sampled only at the clock edge that ends phase `CYC_LEN-1`, so changes inside a machine cycle do not affect that cycle. The first machine cycle after reset is in MODE_TOGGLE with no data move, and it fetches externally only if `ea_pin` was low during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock; one period per phase |
| rst_n | input | 1 | Synchronous active-low reset |
| ea_pin | input | 1 | External-access pin level (1 = internal program memory allowed) |
| pc | input | PC_W | Fetch address for the coming machine cycle |
| xdata_mv | input | 1 | Coming machine cycle performs an external data move |
| quiet_en | input | 1 | Software bit that silences address-latch toggling |
| idle_mode | input | 1 | Idle mode request |
| pdown_mode | input | 1 | Power-down mode request |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-fetch read strobe, active low |
| ale_pd_req | output | 1 | Request for the pad pull-down that keeps `ale` quiet |

## Verification
The bench builds the block with `CYC_LEN` = 6, `PC_W` = 16 and `IMEM_LIMIT` = 64512. This lets each expected strobe pattern be written as one 6-bit word per machine cycle. It also puts the internal/external boundary at addresses 0xFBFF and 0xFC00, so fetches on both sides of the limit can be driven directly. The table-driven part covers every mode and every override of the quiet bit. Two resets with different `ea_pin` levels, together with an `ea_pin` change after reset, expose the latching. A mid-cycle change of the quiet bit shows that sampling happens only at the cycle boundary.

// File: rtl/xbus_strobe_pkg.sv
package xbus_strobe_pkg;

    typedef enum logic [1:0] {
        MODE_TOGGLE = 2'd0,
        MODE_QUIET  = 2'd1,
        MODE_IDLE   = 2'd2,
        MODE_PDOWN  = 2'd3
    } bus_mode_e;

endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
    parameter int CYC_LEN = 6,
    parameter int PH_W    = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            cyc_end
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_LEN - 1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == PH_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign phase   = phase_q;
    assign cyc_end = (phase_q == PH_LAST);

    // R9: a machine cycle ends by restarting the phase at zero
    a_r9_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> (phase == '0));

endmodule

// File: rtl/xbus_mode_fsm.sv
module xbus_mode_fsm
    import xbus_strobe_pkg::*;
#(
    parameter int PC_W       = 16,
    parameter int IMEM_LIMIT = 64512
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_end,
    input  logic            ea_pin,
    input  logic [PC_W-1:0] pc,
    input  logic            xdata_mv,
    input  logic            quiet_en,
    input  logic            idle_mode,
    input  logic            pdown_mode,
    output bus_mode_e       mode,
    output logic            ext_fetch,
    output logic            xdata_q,
    output logic            quiet_q
);

    localparam logic [PC_W:0] LIMIT_EXT = (PC_W + 1)'(IMEM_LIMIT);

    bus_mode_e mode_q;
    bus_mode_e mode_d;
    logic      ea_lat_q;
    logic      pc_hi_q;
    logic      pc_hi_d;
    logic      force_toggle;

    assign pc_hi_d      = ({1'b0, pc} >= LIMIT_EXT);
    assign force_toggle = xdata_mv || pc_hi_d || !ea_lat_q;

    // next mode: one priority decision at each machine-cycle boundary
    always_comb begin
        if (pdown_mode) begin
            mode_d = MODE_PDOWN;
        end else if (idle_mode) begin
            mode_d = MODE_IDLE;
        end else if (quiet_en && !force_toggle) begin
            mode_d = MODE_QUIET;
        end else begin
            mode_d = MODE_TOGGLE;
        end
    end

    // external-access level is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_lat_q <= ea_pin;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_TOGGLE;
            pc_hi_q <= 1'b0;
            xdata_q <= 1'b0;
            quiet_q <= 1'b0;
        end else if (cyc_end) begin
            mode_q  <= mode_d;
            pc_hi_q <= pc_hi_d;
            xdata_q <= xdata_mv;
            quiet_q <= quiet_en;
        end
    end

    assign mode      = mode_q;
    assign ext_fetch = pc_hi_q || !ea_lat_q;

    // R9: mode only moves at a machine-cycle boundary
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> $stable(mode));

    // R5: an external data move never yields the quiet mode
    a_r5_xdata_not_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && xdata_mv && !idle_mode && !pdown_mode) |=> (mode == MODE_TOGGLE));

endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
    import xbus_strobe_pkg::*;
#(
    parameter int CYC_LEN = 6,
    parameter int PH_W    = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  bus_mode_e       mode,
    input  logic            ext_fetch,
    input  logic            xdata_q,
    input  logic            quiet_q,
    output logic            ale,
    output logic            psen_n,
    output logic            ale_pd_req
);

    localparam logic [PH_W-1:0] PH_HALF  = PH_W'(CYC_LEN / 2);
    localparam logic [PH_W-1:0] PH_RD_A  = PH_W'(CYC_LEN / 2 - 1);
    localparam logic [PH_W-1:0] PH_RD_B  = PH_W'(CYC_LEN - 1);

    logic fetch_slot;

    assign fetch_slot = (phase == PH_RD_A) || (phase == PH_RD_B);

    always_comb begin
        ale        = 1'b0;
        psen_n     = 1'b1;
        ale_pd_req = 1'b0;
        unique case (mode)
            MODE_TOGGLE: begin
                ale    = (phase < PH_HALF);
                psen_n = !(ext_fetch && !xdata_q && fetch_slot);
            end
            MODE_QUIET: begin
                ale        = 1'b0;
                ale_pd_req = 1'b1;
            end
            MODE_IDLE: begin
                ale = 1'b1;
            end
            MODE_PDOWN: begin
                ale        = 1'b0;
                ale_pd_req = quiet_q;
            end
        endcase
    end

    // R1: address strobe rises only at the start of a machine cycle
    a_r1_ale_rise_phase0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> (phase == '0));

    // R2: fetch strobe is only active while toggling
    a_r2_psen_only_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> (mode == MODE_TOGGLE));

    // R4: quiet mode keeps the address strobe low and requests the pull-down
    a_r4_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_QUIET) |-> (!ale && ale_pd_req));

    // R7: power-down keeps the fetch strobe inactive and address strobe low
    a_r7_pdown_park: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PDOWN) |-> (psen_n && !ale));

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_strobe_pkg::*;
#(
    parameter int CYC_LEN    = 6,
    parameter int PC_W       = 16,
    parameter int IMEM_LIMIT = 64512
) (
    input  logic            clk_osc,
    input  logic            rst_n,
    input  logic            ea_pin,
    input  logic [PC_W-1:0] pc,
    input  logic            xdata_mv,
    input  logic            quiet_en,
    input  logic            idle_mode,
    input  logic            pdown_mode,
    output logic            ale,
    output logic            psen_n,
    output logic            ale_pd_req
);

    localparam int PH_W = $clog2(CYC_LEN);

    logic [PH_W-1:0] phase;
    logic            cyc_end;
    bus_mode_e       mode;
    logic            ext_fetch;
    logic            xdata_q;
    logic            quiet_q;

    xbus_phase_ctr #(
        .CYC_LEN (CYC_LEN),
        .PH_W    (PH_W)
    ) phase_i (
        .clk     (clk_osc),
        .rst_n   (rst_n),
        .phase   (phase),
        .cyc_end (cyc_end)
    );

    xbus_mode_fsm #(
        .PC_W       (PC_W),
        .IMEM_LIMIT (IMEM_LIMIT)
    ) fsm_i (
        .clk        (clk_osc),
        .rst_n      (rst_n),
        .cyc_end    (cyc_end),
        .ea_pin     (ea_pin),
        .pc         (pc),
        .xdata_mv   (xdata_mv),
        .quiet_en   (quiet_en),
        .idle_mode  (idle_mode),
        .pdown_mode (pdown_mode),
        .mode       (mode),
        .ext_fetch  (ext_fetch),
        .xdata_q    (xdata_q),
        .quiet_q    (quiet_q)
    );

    xbus_strobe_dec #(
        .CYC_LEN (CYC_LEN),
        .PH_W    (PH_W)
    ) dec_i (
        .clk        (clk_osc),
        .rst_n      (rst_n),
        .phase      (phase),
        .mode       (mode),
        .ext_fetch  (ext_fetch),
        .xdata_q    (xdata_q),
        .quiet_q    (quiet_q),
        .ale        (ale),
        .psen_n     (psen_n),
        .ale_pd_req (ale_pd_req)
    );

    // R6: idle parks both strobes high without a pull-down request
    a_r6_idle_park: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (mode == MODE_IDLE) |-> (ale && psen_n && !ale_pd_req));

endmodule

// File: tb/xbus_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module xbus_strobe_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ea_pin = 1'b1;
    logic [15:0] pc = 16'h0000;
    logic        xdata_mv = 1'b0;
    logic        quiet_en = 1'b0;
    logic        idle_mode = 1'b0;
    logic        pdown_mode = 1'b0;
    logic        ale;
    logic        psen_n;
    logic        ale_pd_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xbus_strobe_gen #(
        .CYC_LEN    (6),
        .PC_W       (16),
        .IMEM_LIMIT (64512)
    ) dut_i (
        .clk_osc    (clk_osc_w),
        .rst_n      (rst_n),
        .ea_pin     (ea_pin),
        .pc         (pc),
        .xdata_mv   (xdata_mv),
        .quiet_en   (quiet_en),
        .idle_mode  (idle_mode),
        .pdown_mode (pdown_mode),
        .ale        (ale),
        .psen_n     (psen_n),
        .ale_pd_req (ale_pd_req)
    );

    wire clk_osc_w = clk;

    // {ea, pc, xd, quiet, idle, pdown, ale[5:0], psen_n[5:0], pd_req, tag}
    // pattern bit k holds the value seen in phase k
    localparam logic [37:0] VEC [0:15] = '{
        {1'b1, 16'h0100, 4'b0000, 6'b000111, 6'b111111, 1'b0, 4'd1}, // R1 internal fetch
        {1'b1, 16'hFC00, 4'b0000, 6'b000111, 6'b011011, 1'b0, 4'd2}, // R2 at limit
        {1'b1, 16'hFBFF, 4'b0000, 6'b000111, 6'b111111, 1'b0, 4'd2}, // R2 just below limit
        {1'b1, 16'h0100, 4'b1000, 6'b000111, 6'b111111, 1'b0, 4'd3}, // R3 data move
        {1'b1, 16'hFC00, 4'b1000, 6'b000111, 6'b111111, 1'b0, 4'd3}, // R3 skip on ext fetch
        {1'b1, 16'h0100, 4'b0100, 6'b000000, 6'b111111, 1'b1, 4'd4}, // R4 quiet
        {1'b1, 16'hFBFF, 4'b0100, 6'b000000, 6'b111111, 1'b1, 4'd4}, // R4 quiet below limit
        {1'b1, 16'h0100, 4'b1100, 6'b000111, 6'b111111, 1'b0, 4'd5}, // R5 data move override
        {1'b1, 16'hFC00, 4'b0100, 6'b000111, 6'b011011, 1'b0, 4'd5}, // R5 out-of-range override
        {1'b1, 16'h0100, 4'b0010, 6'b111111, 6'b111111, 1'b0, 4'd6}, // R6 idle
        {1'b1, 16'h0100, 4'b0110, 6'b111111, 6'b111111, 1'b0, 4'd6}, // R6 idle quiet
        {1'b1, 16'h0100, 4'b0101, 6'b000000, 6'b111111, 1'b1, 4'd7}, // R7 pdown quiet
        {1'b1, 16'hFC00, 4'b0001, 6'b000000, 6'b111111, 1'b0, 4'd7}, // R7 pdown loud
        {1'b1, 16'h0100, 4'b0011, 6'b000000, 6'b111111, 1'b0, 4'd7}, // R7 pdown beats idle
        {1'b0, 16'h0100, 4'b0100, 6'b000000, 6'b111111, 1'b1, 4'd8}, // R8 pin low ignored
        {1'b0, 16'h0100, 4'b0000, 6'b000111, 6'b111111, 1'b0, 4'd8}  // R8 still internal
    };

    logic [5:0] obs_ale;
    logic [5:0] obs_psen;
    logic [5:0] obs_pd;

    task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    // samples one machine cycle; now_first samples the current phase first
    task automatic observe(input bit now_first);
        for (int k = 0; k < 6; k++) begin
            if (!(now_first && k == 0)) @(negedge clk);
            obs_ale[k]  = ale;
            obs_psen[k] = psen_n;
            obs_pd[k]   = ale_pd_req;
        end
    endtask

    task automatic do_reset(input logic ea);
        @(negedge clk);
        rst_n = 1'b0;
        ea_pin = ea;
        xdata_mv = 1'b0; quiet_en = 1'b0; idle_mode = 1'b0; pdown_mode = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 reset ale", {5'b0, ale}, 6'd1);
        chk("R9 reset psen_n", {5'b0, psen_n}, 6'd1);
        chk("R9 reset pd_req", {5'b0, ale_pd_req}, 6'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset with external access high; first cycle fetches internally
        do_reset(1'b1);
        observe(1'b1);
        chk("R9 first cycle ale", obs_ale, 6'b000111);
        chk("R9 first cycle psen_n", obs_psen, 6'b111111);

        for (int i = 0; i < 16; i++) begin
            logic [37:0] v;
            v = VEC[i];
            ea_pin     = v[37];
            pc         = v[36:21];
            xdata_mv   = v[20];
            quiet_en   = v[19];
            idle_mode  = v[18];
            pdown_mode = v[17];
            observe(1'b0);
            chk($sformatf("R%0d vec %0d ale", v[3:0], i), obs_ale, v[16:11]);
            chk($sformatf("R%0d vec %0d psen_n", v[3:0], i), obs_psen, v[10:5]);
            chk($sformatf("R%0d vec %0d pd_req", v[3:0], i), obs_pd, {6{v[4]}});
        end

        // R9: quiet bit raised mid-cycle leaves that cycle toggling
        ea_pin = 1'b1; pc = 16'h0100; xdata_mv = 1'b0; quiet_en = 1'b0;
        idle_mode = 1'b0; pdown_mode = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            obs_ale[k] = ale;
            if (k == 2) quiet_en = 1'b1;
        end
        chk("R9 mid-cycle change ignored", obs_ale, 6'b000111);
        observe(1'b0);
        chk("R9 change applied next cycle", obs_ale, 6'b000000);

        // R8: reset with external access low; first cycle fetches externally
        do_reset(1'b0);
        ea_pin = 1'b1;
        observe(1'b1);
        chk("R8 first cycle ale", obs_ale, 6'b000111);
        chk("R8 first cycle psen_n", obs_psen, 6'b011011);

        // R5: latched low level overrides quiet
        pc = 16'h0100; quiet_en = 1'b1;
        observe(1'b0);
        chk("R5 ea low quiet ale", obs_ale, 6'b000111);
        chk("R5 ea low quiet psen_n", obs_psen, 6'b011011);
        chk("R5 ea low quiet pd_req", obs_pd, 6'b000000);

        // R3: data move under external fetch skips both activations
        quiet_en = 1'b0; xdata_mv = 1'b1;
        observe(1'b0);
        chk("R3 ea low data move psen_n", obs_psen, 6'b111111);
        chk("R3 ea low data move ale", obs_ale, 6'b000111);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule